// File: doc/BRIEF.md
# Ready-Latency Packet Transmit Controller

This block sits between a local word source and a streaming packet sink. The source is a show-ahead FIFO whose head word carries data, start and end markers, a packet kind and a nullify request. The sink throttles with a ready line whose meaning is delayed. A ready seen in one cycle grants a transfer slot a fixed number of cycles later, and the number is set by a parameter.

The controller records past ready values. In each granted cycle it drives valid together with the head word and pops that word from the source. It stays silent for a short hold-off after reset. A packet can be nullified, meaning the sink is told to discard it. To do this the controller raises the error line for one beat in the middle of the packet, and only when the packet kind and the packet length allow it. After a nullified packet it leaves one idle cycle.

Top module: `pkt_tx_ctrl`

## Requirements
- R1: `tx_valid` is high in cycle n+LAT only if `snk_ready` was high in cycle n. When the hold-off, the source and the post-nullify gap all permit it, a ready in cycle n always yields a beat in cycle n+LAT.
- R2: LAT = 2 (the default) and LAT = 1 both behave as R1 describes.
- R3: `tx_valid` stays low during reset and for the first 2 cycles after reset is released, even if `snk_ready` is high throughout.
- R4: When `snk_ready` falls, `tx_valid` falls exactly LAT cycles later. When it rises again in the middle of a packet, beats resume exactly LAT cycles later.
- R5: `src_pop` equals `tx_valid`. `tx_data` is the head word in every beat, and `tx_sop`/`tx_eop` are the head word's markers gated by `tx_valid`. Every source word is sent once, in order.
- R6: A nullify request is sampled with the start word of a packet. It raises `tx_err` for exactly one cycle, on the packet's second beat, and only if that beat carries neither start nor end, the kind is 0 (posted with payload) or 1 (completion with payload), and the packet has 3 or more beats. `tx_valid` is high in that cycle.
- R7: A nullify request on a 1-beat or 2-beat packet has no effect: `tx_err` stays low.
- R8: A nullify request on kind 2 (non-posted) or kind 3 (no payload) has no effect: `tx_err` stays low.
- R9: In the cycle after the end beat of a nullified packet, `tx_valid` is low.
- R10: While `src_empty` is high, `tx_valid` and `src_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_empty | input | 1 | Source has no word at its head |
| src_data | input | DW | Head word data |
| src_sop | input | 1 | Head word starts a packet |
| src_eop | input | 1 | Head word ends a packet |
| src_kind | input | 2 | Packet kind, meaningful with the start word (0 posted+data, 1 completion+data, 2 non-posted, 3 no payload) |
| src_nullify | input | 1 | Nullify request, meaningful with the start word |
| src_pop | output | 1 | Consume the head word |
| snk_ready | input | 1 | Sink grant for the cycle LAT ahead |
| tx_valid | output | 1 | Beat transferred this cycle |
| tx_data | output | DW | Beat data |
| tx_sop | output | 1 | Beat starts a packet |
| tx_eop | output | 1 | Beat ends a packet |
| tx_err | output | 1 | Nullify pulse for the current packet |

## Verification
The bench sweeps packet lengths from 1 to 5, all four kinds and both request values, through two instances with LAT 2 and LAT 1. Ready and source availability are irregular, and ready is held high through reset. The corner cases it targets are these:
- If the ready pipe had the wrong depth, valid would fire one cycle early or late around every ready edge.
- If the hold-off were missing, a beat would go out in the first cycle after reset.
- If the nullify gate ignored kind or length, error pulses would appear on short or non-payload packets.
- If the gap were missing, or came from a stale flag, a start beat would follow a nullified end directly, or a later single-beat packet would be stalled for no reason.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  typedef enum logic [1:0] {
    KIND_POSTED_DATA = 2'd0,
    KIND_CPL_DATA    = 2'd1,
    KIND_NONPOSTED   = 2'd2,
    KIND_NO_PAYLOAD  = 2'd3
  } pkt_kind_e;

  // Beat position inside a packet, saturating: 0 start, 1 second, 2 later.
  localparam int BEAT_IDX_W = 2;

  function automatic logic kind_may_nullify(input logic [1:0] kind);
    return (kind == KIND_POSTED_DATA) || (kind == KIND_CPL_DATA);
  endfunction

  function automatic logic [BEAT_IDX_W-1:0] beat_idx_next(input logic [BEAT_IDX_W-1:0] idx);
    return (idx >= 2'd2) ? 2'd2 : idx + 2'd1;
  endfunction

  // Error pulse slot: second beat, neither start nor end.
  function automatic logic is_err_slot(input logic [BEAT_IDX_W-1:0] idx,
                                       input logic sop, input logic eop);
    return (idx == 2'd1) && !sop && !eop;
  endfunction

endpackage

// File: rtl/ptx_ready_pipe.sv
module ptx_ready_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  output logic grant
);
  logic [LAT-1:0] hist;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= ready_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[LAT-2:0], ready_in};
      end
    end
  endgenerate

  // Oldest stage grants the current cycle.
  assign grant = hist[LAT-1];
endmodule

// File: rtl/ptx_startup_gate.sv
module ptx_startup_gate #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic open
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign open = (cnt == LIMIT);
endmodule

// File: rtl/ptx_nullify_ctrl.sv
module ptx_nullify_ctrl
  import pkt_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       w_sop,
  input  logic       w_eop,
  input  logic [1:0] w_kind,
  input  logic       w_req,
  output logic       err,
  output logic       gap
);
  logic                  armed;
  logic                  in_pkt;
  logic                  nulled;
  logic [BEAT_IDX_W-1:0] idx;

  assign err = beat && armed && in_pkt && is_err_slot(idx, w_sop, w_eop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      in_pkt <= 1'b0;
      nulled <= 1'b0;
      idx    <= '0;
      gap    <= 1'b0;
    end else begin
      gap <= beat && w_eop && !w_sop && nulled;
      if (beat) begin
        if (w_sop) begin
          armed  <= w_req && kind_may_nullify(w_kind);
          in_pkt <= !w_eop;
          idx    <= 2'd1;
          nulled <= 1'b0;
        end else begin
          idx <= beat_idx_next(idx);
          if (w_eop) begin
            in_pkt <= 1'b0;
            armed  <= 1'b0;
            nulled <= 1'b0;
          end else begin
            nulled <= nulled | err;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl #(
  parameter int DW   = 16,
  parameter int LAT  = 2,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_empty,
  input  logic [DW-1:0] src_data,
  input  logic          src_sop,
  input  logic          src_eop,
  input  logic [1:0]    src_kind,
  input  logic          src_nullify,
  output logic          src_pop,
  input  logic          snk_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic          tx_err
);
  logic grant;
  logic open;
  logic gap;
  logic beat;
  logic err;

  ptx_ready_pipe #(.LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ready_in(snk_ready), .grant(grant)
  );

  ptx_startup_gate #(.HOLD(HOLD)) u_gate (
    .clk(clk), .rst_n(rst_n), .open(open)
  );

  assign beat = grant && open && !src_empty && !gap;

  ptx_nullify_ctrl u_null (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .w_sop(src_sop), .w_eop(src_eop), .w_kind(src_kind), .w_req(src_nullify),
    .err(err), .gap(gap)
  );

  assign src_pop  = beat;
  assign tx_valid = beat;
  assign tx_data  = src_data;
  assign tx_sop   = beat && src_sop;
  assign tx_eop   = beat && src_eop;
  assign tx_err   = err;
endmodule

// File: rtl/pkt_tx_ctrl_chk.sv
module pkt_tx_ctrl_chk #(
  parameter int LAT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic snk_ready,
  input logic tx_valid,
  input logic tx_sop,
  input logic tx_eop,
  input logic tx_err,
  input logic src_empty,
  input logic src_pop
);
  logic [1:0] since;
  logic       saw_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since   <= '0;
      saw_err <= 1'b0;
    end else begin
      if (since != 2'd3) since <= since + 2'd1;
      if (tx_valid && tx_eop) saw_err <= 1'b0;
      else if (tx_err)        saw_err <= 1'b1;
    end
  end

  generate
    if (LAT == 1) begin : g_l1
      // R1
      grant_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(snk_ready, 1));
    end else begin : g_l2
      // R1
      grant_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(snk_ready, 2));
    end
  endgenerate

  // R3
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (since >= 2'd2));

  // R6
  err_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (tx_valid && !tx_sop && !tx_eop));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |=> !tx_err);

  // R9
  null_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_eop && saw_err) |=> !tx_valid);

  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_empty |-> (!tx_valid && !src_pop));
endmodule

bind pkt_tx_ctrl pkt_tx_ctrl_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .snk_ready(snk_ready), .tx_valid(tx_valid),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err),
  .src_empty(src_empty), .src_pop(src_pop)
);

// File: tb/pkt_tx_ctrl_test.sv
module pkt_tx_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NWMAX  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_data [NWMAX];
  logic        m_sop  [NWMAX];
  logic        m_eop  [NWMAX];
  logic        m_nul  [NWMAX];
  logic [1:0]  m_kind [NWMAX];
  int          m_len  [NWMAX];
  int          nw = 0;

  logic [1:0]  rdy, empt, s_sop, s_eop, s_nul;
  logic [1:0]  kind0, kind1;
  logic [15:0] sd0, sd1;
  wire  [1:0]  pop, vo, so, eo, er;
  wire  [15:0] td0, td1;

  pkt_tx_ctrl #(.DW(16), .LAT(2)) uut (
    .clk(clk), .rst_n(rst_n), .src_empty(empt[0]), .src_data(sd0),
    .src_sop(s_sop[0]), .src_eop(s_eop[0]), .src_kind(kind0), .src_nullify(s_nul[0]),
    .src_pop(pop[0]), .snk_ready(rdy[0]), .tx_valid(vo[0]), .tx_data(td0),
    .tx_sop(so[0]), .tx_eop(eo[0]), .tx_err(er[0]));

  pkt_tx_ctrl #(.DW(16), .LAT(1)) uut_l1 (
    .clk(clk), .rst_n(rst_n), .src_empty(empt[1]), .src_data(sd1),
    .src_sop(s_sop[1]), .src_eop(s_eop[1]), .src_kind(kind1), .src_nullify(s_nul[1]),
    .src_pop(pop[1]), .snk_ready(rdy[1]), .tx_valid(vo[1]), .tx_data(td1),
    .tx_sop(so[1]), .tx_eop(eo[1]), .tx_err(er[1]));

  // reference state per instance (0: LAT 2, 1: LAT 1)
  int since [2];
  int head  [2];
  int idx   [2];
  bit h0 [2], h1 [2], pon [2], arm [2], nld [2], gap [2];
  int errs [2], gaps [2];
  bit avail;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rdy_of(input int c);
    if (c < 40) return 1'b1;
    return ((c * 5 + c / 7) % 6) < 4;
  endfunction

  task automatic drive_src(input int k);
    bit has;
    int h;
    has = avail && (head[k] < nw);
    h   = (head[k] < nw) ? head[k] : 0;
    empt[k]  = !has;
    s_sop[k] = m_sop[h];
    s_eop[k] = m_eop[h];
    s_nul[k] = m_nul[h];
    if (k == 0) begin sd0 = m_data[h]; kind0 = m_kind[h]; end
    else        begin sd1 = m_data[h]; kind1 = m_kind[h]; end
  endtask

  task automatic step(input int k);
    bit grant, ev, ee, gapn;
    int h;
    string vt, et;
    logic [15:0] td;
    grant = (k == 0) ? h1[k] : h0[k];
    ev = grant && since[k] >= 2 && avail && head[k] < nw && !gap[k];
    h  = (head[k] < nw) ? head[k] : 0;
    ee = ev && arm[k] && pon[k] && idx[k] == 1 && !m_sop[h] && !m_eop[h];
    if (since[k] < 2)  vt = "R3";
    else if (gap[k])   vt = "R9";
    else if (!avail)   vt = "R10";
    else               vt = (k == 1) ? "R1 R4 R2" : "R1 R4";
    check(vo[k] == ev, vt, vo[k], ev);
    check(pop[k] == ev, "R5 pop", pop[k], ev);
    if (ev) begin
      td = (k == 0) ? td0 : td1;
      check(td == m_data[h], "R5 data", td, m_data[h]);
      check(so[k] == m_sop[h] && eo[k] == m_eop[h], "R5 markers",
            {so[k], eo[k]}, {m_sop[h], m_eop[h]});
    end
    if (m_len[h] < 3)       et = "R7";
    else if (m_kind[h] > 1) et = "R8";
    else                    et = "R6";
    check(er[k] == ee, et, er[k], ee);
    if (ee) errs[k]++;
    gapn = ev && m_eop[h] && !m_sop[h] && nld[k];
    if (gapn) gaps[k]++;
    if (ev) begin
      if (m_sop[h]) begin
        arm[k] = m_nul[h] && (m_kind[h] < 2);
        pon[k] = !m_eop[h];
        idx[k] = 1;
        nld[k] = 0;
      end else begin
        if (idx[k] < 2) idx[k]++;
        if (m_eop[h]) begin pon[k] = 0; arm[k] = 0; nld[k] = 0; end
        else nld[k] = nld[k] | ee;
      end
      head[k]++;
    end
    gap[k] = gapn;
    h1[k] = h0[k];
    h0[k] = rdy[k];
    if (since[k] < 3) since[k]++;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // sweep: length 1..5, kind 0..3, nullify 0..1
    for (int len = 1; len <= 5; len++)
      for (int kd = 0; kd < 4; kd++)
        for (int nu = 0; nu < 2; nu++)
          for (int b = 0; b < len; b++) begin
            m_data[nw] = 16'(nw * 3 + 1);
            m_sop[nw]  = (b == 0);
            m_eop[nw]  = (b == len - 1);
            m_nul[nw]  = nu[0];
            m_kind[nw] = kd[1:0];
            m_len[nw]  = len;
            nw++;
          end
    for (int k = 0; k < 2; k++) begin
      since[k] = 0; head[k] = 0; idx[k] = 0; h0[k] = 0; h1[k] = 0;
      pon[k] = 0; arm[k] = 0; nld[k] = 0; gap[k] = 0; errs[k] = 0; gaps[k] = 0;
    end
    avail = 1'b1;
    rdy = 2'b11;
    drive_src(0);
    drive_src(1);
    repeat (4) @(negedge clk);
    #2;
    check(vo == 2'b00 && er == 2'b00, "R3 reset", {vo, er}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 900; c++) begin
      avail = (c % 13) != 7;
      rdy   = {2{rdy_of(c)}};
      drive_src(0);
      drive_src(1);
      #2;
      step(0);
      step(1);
      @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      check(head[k] == nw, "R5 all words sent", head[k], nw);
      check(errs[k] == 6, "R6 pulse count", errs[k], 6);
      check(gaps[k] == 6, "R9 gap count", gaps[k], 6);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule